// File: doc/BRIEF.md
# Ethernet PHY Control Register with Mode Resolution

This block holds the main control word of a 10/100 Ethernet PHY behind a plain single-register write/read port, and turns that word into the operating mode the rest of the PHY uses. The effective speed, duplex and auto-negotiation enable come from three places: bits of the control word, a strap input that selects between hardware and software control, and dedicated select pins. When auto-negotiation is on, its outcome arrives as plain input signals and is passed through as the resolved mode.

The same word carries a loopback switch. In loopback the transmit nibbles from the MAC side come back on the receive side after a fixed two-cycle pipeline. The line transmitter and line receiver are switched off, and line receive data is blanked. Collision reporting is suppressed unless a test bit keeps it alive. The auto-negotiation protocol, the analog front end and the serial management framing sit outside this block.

Top module: `phy_ctrl_core`

## Requirements
- R1: After reset the control word reads 16'h3000: loopback (bit 14) 0, speed (bit 13) 1, auto-negotiation enable (bit 12) 1, duplex (bit 8) 0, collision test (bit 7) 0. The resolved outputs start at speed100 1, full duplex 0, auto-negotiation 1.
- R2: A write on `wr_en_i` is visible on `rd_data_o` from the cycle after the strobe. Only bits 14, 13, 12, 8 and 7 are stored. All other bits read 0 whatever was written. Without a strobe the word holds its value.
- R3: With `sw_mode_i`=0 (hardware mode), bits 13 and 12 have no effect. `speed100_o` follows `spd_pin_i` and `an_on_o` follows `an_pin_i`. Duplex follows `an_dup_i` when `an_pin_i`=1, and bit 8 otherwise.
- R4: With `sw_mode_i`=1 and bit 12 set, bits 13 and 8 have no effect. `an_on_o`=1, and speed and duplex follow `an_spd_i` and `an_dup_i`.
- R5: With `sw_mode_i`=1 and bit 12 clear, `an_on_o`=0. Bit 13 selects the speed (0 = 10 Mb/s, 1 = 100 Mb/s) and bit 8 selects the duplex (1 = full).
- R6: The resolved outputs are registered. They reflect the control word and the pins as they stood one cycle earlier, so a write appears on them two cycles after its strobe.
- R7: With bit 14 set, `rxd_o`/`rxdv_o`/`rxer_o` carry `txd_i`/`txen_i`/`txer_i` delayed by exactly two clock cycles, and the line receive inputs are ignored. With bit 14 clear, these outputs pass the line receive inputs through in the same cycle.
- R8: With bit 14 set, `line_txd_o`, `line_txen_o` and `line_txer_o` are 0, and `line_tx_on_o` and `line_rx_on_o` are 0. With bit 14 clear, the transmit inputs pass to the line and both enables are 1.
- R9: `col_o` equals `line_col_i`, except that in loopback with bit 7 clear it is 0. Bit 7 set keeps collisions reported during loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 16 | Write value |
| rd_data_o | output | 16 | Current control word |
| sw_mode_i | input | 1 | Strap: 1 = software control, 0 = hardware pins |
| spd_pin_i | input | 1 | Hardware speed select (1 = 100 Mb/s) |
| an_pin_i | input | 1 | Hardware auto-negotiation select |
| an_spd_i | input | 1 | Auto-negotiation result speed (1 = 100 Mb/s) |
| an_dup_i | input | 1 | Auto-negotiation result duplex (1 = full) |
| speed100_o | output | 1 | Resolved speed, also the link rate status |
| full_dup_o | output | 1 | Resolved duplex |
| an_on_o | output | 1 | Resolved auto-negotiation enable |
| txd_i | input | 4 | MAC transmit nibble |
| txen_i | input | 1 | MAC transmit enable |
| txer_i | input | 1 | MAC transmit error |
| rxd_o | output | 4 | Receive nibble to the MAC |
| rxdv_o | output | 1 | Receive data valid |
| rxer_o | output | 1 | Receive error |
| col_o | output | 1 | Collision to the MAC |
| line_rxd_i | input | 4 | Line-side receive nibble |
| line_rxdv_i | input | 1 | Line-side receive valid |
| line_rxer_i | input | 1 | Line-side receive error |
| line_col_i | input | 1 | Line-side collision detect |
| line_txd_o | output | 4 | Nibble to the line transmitter |
| line_txen_o | output | 1 | Enable to the line transmitter |
| line_txer_o | output | 1 | Error to the line transmitter |
| line_tx_on_o | output | 1 | Line transmitter power enable |
| line_rx_on_o | output | 1 | Line receiver power enable |

## Verification
Each control word in a set is held for a stretch of cycles under both strap settings. Meanwhile the select pins, the auto-negotiation results and the data on both the transmit and line-receive sides change every cycle. Random pins and results running against fixed word bits show which source each resolved output follows: varying pins and results separate hardware from software resolution, and flipping bit 12 separates the forced-mode path from the negotiated one. The words with bit 14 set push a changing transmit stream through loopback, which exposes any error in pipeline depth or any leak of line data. Bit 7 toggled together with random line collisions separates suppressed collisions from kept ones. Writing all ones and then all zeros shows which bits are stored.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

   localparam int REG_W     = 16;
   localparam int BIT_LOOP  = 14;
   localparam int BIT_SPD   = 13;
   localparam int BIT_ANE   = 12;
   localparam int BIT_DUP   = 8;
   localparam int BIT_COLT  = 7;

   localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << BIT_LOOP) | (REG_W'(1) << BIT_SPD) | (REG_W'(1) << BIT_ANE) |
      (REG_W'(1) << BIT_DUP)  | (REG_W'(1) << BIT_COLT);

   localparam logic [REG_W-1:0] RESET_VAL =
      (REG_W'(1) << BIT_SPD) | (REG_W'(1) << BIT_ANE);

   typedef struct packed {
      logic spd100;
      logic full;
      logic an_on;
   } mode_t;

   localparam mode_t MODE_RESET = '{spd100: 1'b1, full: 1'b0, an_on: 1'b1};

endpackage

// File: rtl/phyctl_regs.sv
module phyctl_regs
   import phyctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] ctrl_o
);

   logic [REG_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= RESET_VAL;
      else if (wr_en_i) ctrl_q <= wr_data_i & IMPL_MASK;
   end

   assign ctrl_o = ctrl_q;

   // R2: without a strobe the word keeps its value
   a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(ctrl_o));

endmodule

// File: rtl/phyctl_resolve.sv
module phyctl_resolve
   import phyctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] ctrl_i,
   input  logic             sw_mode_i,
   input  logic             spd_pin_i,
   input  logic             an_pin_i,
   input  logic             an_spd_i,
   input  logic             an_dup_i,
   output mode_t            mode_o
);

   mode_t mode_d, mode_q;
   logic  an_sel;

   always_comb begin
      an_sel = sw_mode_i ? ctrl_i[BIT_ANE] : an_pin_i;
      mode_d.an_on = an_sel;
      if (an_sel) mode_d.full = an_dup_i;
      else        mode_d.full = ctrl_i[BIT_DUP];
      if (!sw_mode_i)  mode_d.spd100 = spd_pin_i;
      else if (an_sel) mode_d.spd100 = an_spd_i;
      else             mode_d.spd100 = ctrl_i[BIT_SPD];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_RESET;
      else        mode_q <= mode_d;
   end

   assign mode_o = mode_q;

   // R4: software mode with negotiation on follows the negotiation result
   a_r4_follow_result: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode_i && ctrl_i[BIT_ANE]) |=>
         (mode_o.spd100 == $past(an_spd_i) && mode_o.full == $past(an_dup_i) && mode_o.an_on));

   // R3: hardware mode takes speed and negotiation enable from the pins
   a_r3_pins_rule: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_mode_i |=> (mode_o.spd100 == $past(spd_pin_i) && mode_o.an_on == $past(an_pin_i)));

endmodule

// File: rtl/phyctl_loop.sv
module phyctl_loop #(
   parameter int NIB_W       = 4,
   parameter int LOOP_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loop_en_i,
   input  logic             col_keep_i,
   input  logic [NIB_W-1:0] txd_i,
   input  logic             txen_i,
   input  logic             txer_i,
   input  logic [NIB_W-1:0] line_rxd_i,
   input  logic             line_rxdv_i,
   input  logic             line_rxer_i,
   input  logic             line_col_i,
   output logic [NIB_W-1:0] rxd_o,
   output logic             rxdv_o,
   output logic             rxer_o,
   output logic             col_o,
   output logic [NIB_W-1:0] line_txd_o,
   output logic             line_txen_o,
   output logic             line_txer_o,
   output logic             line_tx_on_o,
   output logic             line_rx_on_o
);

   localparam int BUS_W     = NIB_W + 2;
   localparam int MAX_STAGE = 512 / NIB_W;

   if (NIB_W < 1) begin : g_bad_width
      $error("phyctl_loop: NIB_W must be at least 1");
   end
   if (LOOP_STAGES < 1 || LOOP_STAGES >= MAX_STAGE) begin : g_bad_depth
      $error("phyctl_loop: loopback latency must be 1 stage or more and under 512 bit times");
   end

   logic [BUS_W-1:0] stage_q [LOOP_STAGES];
   logic [BUS_W-1:0] tx_bus, loop_bus;

   assign tx_bus = {txer_i, txen_i, txd_i};

   for (genvar g = 0; g < LOOP_STAGES; g++) begin : g_pipe
      logic [BUS_W-1:0] src;
      if (g == 0) begin : g_head
         assign src = tx_bus;
      end else begin : g_body
         assign src = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[g] <= '0;
         else        stage_q[g] <= src;
      end
   end

   assign loop_bus = stage_q[LOOP_STAGES-1];

   always_comb begin
      if (loop_en_i) begin
         {rxer_o, rxdv_o, rxd_o} = loop_bus;
         line_txd_o  = '0;
         line_txen_o = 1'b0;
         line_txer_o = 1'b0;
      end else begin
         rxd_o       = line_rxd_i;
         rxdv_o      = line_rxdv_i;
         rxer_o      = line_rxer_i;
         line_txd_o  = txd_i;
         line_txen_o = txen_i;
         line_txer_o = txer_i;
      end
   end

   assign col_o        = line_col_i & (~loop_en_i | col_keep_i);
   assign line_tx_on_o = ~loop_en_i;
   assign line_rx_on_o = ~loop_en_i;

   logic [1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   if (LOOP_STAGES == 2) begin : g_chk2
      // R7: in loopback the valid seen at receive is the transmit enable of two cycles ago
      a_r7_loop_latency: assert property (@(posedge clk) disable iff (!rst_n)
         (warm_q >= 2'd2 && loop_en_i) |-> (rxdv_o == $past(txen_i, 2) && rxd_o == $past(txd_i, 2)));
   end

   // R8: the line transmitter stays silent in loopback
   a_r8_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en_i |-> (!line_txen_o && !line_txer_o && !line_tx_on_o && !line_rx_on_o));

   // R9: collisions are hidden in loopback unless kept by the test bit
   a_r9_col_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en_i && !col_keep_i) |-> !col_o);

endmodule

// File: rtl/phy_ctrl_core.sv
module phy_ctrl_core
   import phyctl_pkg::*;
#(
   parameter int NIB_W       = 4,
   parameter int LOOP_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [15:0]      wr_data_i,
   output logic [15:0]      rd_data_o,
   input  logic             sw_mode_i,
   input  logic             spd_pin_i,
   input  logic             an_pin_i,
   input  logic             an_spd_i,
   input  logic             an_dup_i,
   output logic             speed100_o,
   output logic             full_dup_o,
   output logic             an_on_o,
   input  logic [NIB_W-1:0] txd_i,
   input  logic             txen_i,
   input  logic             txer_i,
   output logic [NIB_W-1:0] rxd_o,
   output logic             rxdv_o,
   output logic             rxer_o,
   output logic             col_o,
   input  logic [NIB_W-1:0] line_rxd_i,
   input  logic             line_rxdv_i,
   input  logic             line_rxer_i,
   input  logic             line_col_i,
   output logic [NIB_W-1:0] line_txd_o,
   output logic             line_txen_o,
   output logic             line_txer_o,
   output logic             line_tx_on_o,
   output logic             line_rx_on_o
);

   if (REG_W != 16) begin : g_bad_reg
      $error("phy_ctrl_core: control word must be 16 bits");
   end

   logic [REG_W-1:0] ctrl;
   mode_t            mode;

   phyctl_regs i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .ctrl_o    (ctrl)
   );

   phyctl_resolve i_resolve (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_i    (ctrl),
      .sw_mode_i (sw_mode_i),
      .spd_pin_i (spd_pin_i),
      .an_pin_i  (an_pin_i),
      .an_spd_i  (an_spd_i),
      .an_dup_i  (an_dup_i),
      .mode_o    (mode)
   );

   phyctl_loop #(.NIB_W(NIB_W), .LOOP_STAGES(LOOP_STAGES)) i_loop (
      .clk          (clk),
      .rst_n        (rst_n),
      .loop_en_i    (ctrl[BIT_LOOP]),
      .col_keep_i   (ctrl[BIT_COLT]),
      .txd_i        (txd_i),
      .txen_i       (txen_i),
      .txer_i       (txer_i),
      .line_rxd_i   (line_rxd_i),
      .line_rxdv_i  (line_rxdv_i),
      .line_rxer_i  (line_rxer_i),
      .line_col_i   (line_col_i),
      .rxd_o        (rxd_o),
      .rxdv_o       (rxdv_o),
      .rxer_o       (rxer_o),
      .col_o        (col_o),
      .line_txd_o   (line_txd_o),
      .line_txen_o  (line_txen_o),
      .line_txer_o  (line_txer_o),
      .line_tx_on_o (line_tx_on_o),
      .line_rx_on_o (line_rx_on_o)
   );

   assign rd_data_o  = ctrl;
   assign speed100_o = mode.spd100;
   assign full_dup_o = mode.full;
   assign an_on_o    = mode.an_on;

   // R5: forced software mode takes speed and duplex from the word of the previous cycle
   a_r5_forced_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode_i && !rd_data_o[BIT_ANE]) |=>
         (speed100_o == $past(rd_data_o[BIT_SPD]) && full_dup_o == $past(rd_data_o[BIT_DUP]) && !an_on_o));

   // R2: bits outside the stored set never read as 1
   a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> ((rd_data_o & ~IMPL_MASK) == '0));

endmodule

// File: tb/test_phy_ctrl_core.sv
module test_phy_ctrl_core;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        wr_en = 0;
   logic [15:0] wr_data = 0;
   logic        sw_mode = 1, spd_pin = 0, an_pin = 0, an_spd = 0, an_dup = 0;
   logic [3:0]  txd = 0, line_rxd = 0;
   logic        txen = 0, txer = 0, line_rxdv = 0, line_rxer = 0, line_col = 0;

   logic [15:0] rd_data;
   logic        speed100, full_dup, an_on;
   logic [3:0]  rxd, line_txd;
   logic        rxdv, rxer, col, line_txen, line_txer, line_tx_on, line_rx_on;

   phy_ctrl_core i_phy_ctrl_core (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
      .sw_mode_i(sw_mode), .spd_pin_i(spd_pin), .an_pin_i(an_pin), .an_spd_i(an_spd), .an_dup_i(an_dup),
      .speed100_o(speed100), .full_dup_o(full_dup), .an_on_o(an_on),
      .txd_i(txd), .txen_i(txen), .txer_i(txer),
      .rxd_o(rxd), .rxdv_o(rxdv), .rxer_o(rxer), .col_o(col),
      .line_rxd_i(line_rxd), .line_rxdv_i(line_rxdv), .line_rxer_i(line_rxer), .line_col_i(line_col),
      .line_txd_o(line_txd), .line_txen_o(line_txen), .line_txer_o(line_txer),
      .line_tx_on_o(line_tx_on), .line_rx_on_o(line_rx_on)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   // behavioural reference model
   logic [15:0] m_reg;
   logic        m_spd, m_dup, m_an;
   logic [5:0]  m_pipe [$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_reg = 16'h3000;
         m_spd = 1; m_dup = 0; m_an = 1;
         m_pipe = {6'd0, 6'd0};
      end else begin
         logic ane;
         ane = sw_mode ? m_reg[12] : an_pin;
         m_an  = ane;
         m_dup = ane ? an_dup : m_reg[8];
         m_spd = !sw_mode ? spd_pin : (ane ? an_spd : m_reg[13]);
         if (wr_en) m_reg = wr_data & 16'h7180;
         m_pipe.push_back({txer, txen, txd});
         void'(m_pipe.pop_front());
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         logic lp;
         logic [5:0] exp_rx;
         lp = m_reg[14];
         exp_rx = lp ? m_pipe[0] : {line_rxer, line_rxdv, line_rxd};
         chk("R1/R2 control word", rd_data, m_reg);
         chk("R3/R4/R5/R6 resolved mode", {13'd0, speed100, full_dup, an_on}, {13'd0, m_spd, m_dup, m_an});
         chk("R7 receive side", {10'd0, rxer, rxdv, rxd}, {10'd0, exp_rx});
         chk("R8 line transmit", {8'd0, line_tx_on, line_rx_on, line_txer, line_txen, line_txd},
             lp ? 16'd0 : {8'd0, 1'b1, 1'b1, txer, txen, txd});
         chk("R9 collision", {15'd0, col}, {15'd0, line_col & (!lp | m_reg[7])});
      end
   end

   task automatic drive_random();
      spd_pin   = 1'($urandom);
      an_pin    = 1'($urandom);
      an_spd    = 1'($urandom);
      an_dup    = 1'($urandom);
      txd       = 4'($urandom);
      txen      = 1'($urandom);
      txer      = 1'($urandom);
      line_rxd  = 4'($urandom);
      line_rxdv = 1'($urandom);
      line_rxer = 1'($urandom);
      line_col  = 1'($urandom);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         wr_en = 0;
         drive_random();
      end
   endtask

   task automatic write_word(input logic [15:0] v);
      @(negedge clk); #1;
      wr_en = 1; wr_data = v;
      drive_random();
   endtask

   logic [15:0] words [10] = '{16'hFFFF, 16'h0000, 16'h2100, 16'h1000, 16'h3100,
                               16'h4000, 16'h4080, 16'h6180, 16'h5E7F, 16'h0100};

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            @(negedge clk); #1 rst_n = 1;
            // R1: reset values held with pins idle and no writes
            repeat (3) begin @(negedge clk); #1; end
            for (int s = 0; s < 2; s++) begin
               sw_mode = (s == 0);
               for (int w = 0; w < 10; w++) begin
                  write_word(words[w]);
                  run(24);
               end
            end
            // strap changes while a word is held
            write_word(16'h2100);
            for (int k = 0; k < 20; k++) begin
               @(negedge clk); #1;
               wr_en = 0; drive_random(); sw_mode = 1'($urandom);
            end
            run(4);
         end
         begin
            repeat (20000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule